// File: doc/BRIEF.md
# Four-Channel Pulse Generator with Boundary-Synchronised Updates

This block produces four independent pulse-width-modulated outputs. Software controls it through a plain 32-bit register port: an address, a write strobe and write data go in, and read data comes back combinationally for the address presented. A shared free-running divider supplies each channel with a tick at a rate of its own choosing, a power of two of the input clock. Each channel counts those ticks through a programmable period. It drives its starting level for a programmable number of counts and then the opposite level for the remainder of the period.

Channels are started and stopped through two global registers in which each set bit names one channel. A third global register reports which channels are running. While a channel is stopped, its duty and period are written directly. While it runs, those two registers are frozen. New values then go through a single staging register per channel, and a bit in the channel's configuration register decides whether a staged value targets duty or period. The staged value is held until the running period ends, so a period is never cut short or stretched partway through.

Top module: `pwm_quad`

## Requirements
- R1: A write to the start register at 0x004 sets channel n running for every 1 in bit n (n = 0..3). The run state appears in bits 3:0 of the status register at 0x00C. A 0 bit in a start or stop write leaves that channel's run state unchanged.
- R2: A write to the stop register at 0x008 halts channel n for every 1 in bit n. A halted channel drives its polarity level and clears its count, so a later start begins a fresh period at count 0.
- R3: Channel n's registers sit in a 32-byte window at 0x200 + 0x20*n: configuration at +0x00, duty at +0x04, period at +0x08 and staging at +0x10. A write to one channel leaves the others unchanged.
- R4: The configuration register holds the prescale exponent in bits 3:0, the polarity (the level at the start of each period) in bit 9 and the staging target in bit 10. All other bits read back as 0.
- R5: With an exponent e of 0 to 10, the count advances once every 2^e clocks. An exponent of 11 to 15 is reserved and freezes the count.
- R6: A running channel counts 0 to period-1 and wraps. It drives the polarity level while count < duty and the opposite level otherwise. A duty of 0 gives the opposite level all period, a duty of period or more gives the polarity level all period, and a period of 0 holds the polarity level.
- R7: Duty and period keep only write-data bits 15:0. Bits 31:16 read back as 0.
- R8: While a channel is stopped, writes to its duty and period registers take effect at once. While it runs, such writes are ignored.
- R9: A staging write to a running channel is held and then copied into duty (target bit 0) or period (target bit 1) at the end of the current period. The target is taken from the configuration at the time of the write.
- R10: A staging write to a stopped channel goes straight into the register picked by the target bit.
- R11: After reset, all channels are stopped, every register reads 0 and every output is low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
On every cycle, the bound checker confirms that start and stop writes move only the run bits they name. It also confirms that a stopped channel sits at its polarity level with a cleared count, that a running count stays below a non-zero period, and that the period never changes in the middle of a period. Only the bench scenarios can show the cycle-exact waveform shapes: when a staged value lands at the boundary rather than earlier, the run lengths produced by each prescale exponent, the freezing effect of a reserved exponent, and the readback masking of unused bits.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    // global register byte addresses
    localparam int unsigned GLB_START  = 32'h004;
    localparam int unsigned GLB_STOP   = 32'h008;
    localparam int unsigned GLB_STATUS = 32'h00C;

    // per-channel window placement
    localparam int unsigned CH_BASE = 32'h200;
    localparam int unsigned CH_SPAN = 32'h020;
    localparam int unsigned WIN_W   = 5;

    // offsets inside a channel window
    localparam logic [4:0] OFS_CFG  = 5'h00;
    localparam logic [4:0] OFS_DUTY = 5'h04;
    localparam logic [4:0] OFS_PER  = 5'h08;
    localparam logic [4:0] OFS_STG  = 5'h10;

    // configuration field positions
    localparam int unsigned CFG_POL_BIT = 9;
    localparam int unsigned CFG_TGT_BIT = 10;

    typedef struct packed {
        logic [3:0] psc;   // prescale exponent
        logic       pol;   // level at start of period
        logic       tgt;   // staging target: 0 duty, 1 period
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_DUTY,
        SEL_PER,
        SEL_STG
    } ch_reg_e;

endpackage

// File: rtl/pwm_quad_div.sv
module pwm_quad_div #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] div_cnt
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign div_cnt = cnt_q;

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DIV_W   = 10,
    parameter int unsigned PSC_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cnt,
    input  logic             set_run,
    input  logic             clr_run,
    input  ch_reg_e          wr_sel,
    input  logic [CNT_W-1:0] wr_val,
    input  cfg_t             wr_cfg,
    output logic             pwm_o,
    output logic             run_o,
    output cfg_t             cfg_o,
    output logic [CNT_W-1:0] duty_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] pend_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        cfg_t             cfg;
        logic             run;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pend_val;
        logic             pend_tgt;
        logic             pend_vld;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic [DIV_W-1:0] tick_mask;
    logic             tick;
    logic             at_end;

    always_comb begin
        // tick when the low e divider bits are all ones; reserved e never ticks
        tick_mask = ~({DIV_W{1'b1}} << st_q.cfg.psc);
        tick      = (32'(st_q.cfg.psc) <= PSC_MAX) && ((div_cnt & tick_mask) == tick_mask);
        at_end    = st_q.run && tick &&
                    ((st_q.per == '0) || (st_q.cnt == st_q.per - CNT_W'(1)));

        st_d = st_q;

        if (st_q.run && tick) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + CNT_W'(1);
        end

        // staged value lands only at the period boundary
        if (at_end && st_q.pend_vld) begin
            if (st_q.pend_tgt) st_d.per  = st_q.pend_val;
            else               st_d.duty = st_q.pend_val;
            st_d.pend_vld = 1'b0;
        end

        unique case (wr_sel)
            SEL_CFG:  st_d.cfg = wr_cfg;
            SEL_DUTY: if (!st_q.run) st_d.duty = wr_val;
            SEL_PER:  if (!st_q.run) st_d.per  = wr_val;
            SEL_STG: begin
                if (st_q.run) begin
                    st_d.pend_val = wr_val;
                    st_d.pend_tgt = st_q.cfg.tgt;
                    st_d.pend_vld = 1'b1;
                end else if (st_q.cfg.tgt) begin
                    st_d.per = wr_val;
                end else begin
                    st_d.duty = wr_val;
                end
            end
            default: ;
        endcase

        if (set_run) st_d.run = 1'b1;
        if (clr_run) begin
            st_d.run      = 1'b0;
            st_d.cnt      = '0;
            st_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o  = st_q.cfg.pol ^ (st_q.run && (st_q.per != '0) && (st_q.cnt >= st_q.duty));
    assign run_o  = st_q.run;
    assign cfg_o  = st_q.cfg;
    assign duty_o = st_q.duty;
    assign per_o  = st_q.per;
    assign pend_o = st_q.pend_val;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned PSC_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int unsigned DIV_W    = PSC_MAX;
    localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned WIN_TOP  = NUM_CH * CH_SPAN;

    logic [DIV_W-1:0]    div_cnt;
    logic [ADDR_W-1:0]   rel;
    logic                in_ch;
    logic [CH_IDX_W-1:0] ch_idx;
    logic [WIN_W-1:0]    ofs;
    logic                start_hit, stop_hit;
    ch_reg_e             reg_sel;
    cfg_t                wr_cfg;
    cfg_t                rd_cfg;
    logic                unused_wdata_hi;

    cfg_t             cfg_arr  [NUM_CH];
    logic [CNT_W-1:0] duty_arr [NUM_CH];
    logic [CNT_W-1:0] per_arr  [NUM_CH];
    logic [CNT_W-1:0] pend_arr [NUM_CH];
    logic [CNT_W-1:0] cnt_arr  [NUM_CH];
    logic [NUM_CH-1:0] run_vec;
    logic [NUM_CH-1:0] pol_vec;

    pwm_quad_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_cnt (div_cnt)
    );

    // address decode
    always_comb begin
        rel       = bus_addr - ADDR_W'(CH_BASE);
        in_ch     = (bus_addr >= ADDR_W'(CH_BASE)) && (rel < ADDR_W'(WIN_TOP));
        ch_idx    = rel[WIN_W +: CH_IDX_W];
        ofs       = rel[WIN_W-1:0];
        start_hit = bus_we && (bus_addr == ADDR_W'(GLB_START));
        stop_hit  = bus_we && (bus_addr == ADDR_W'(GLB_STOP));
        reg_sel   = SEL_NONE;
        if (bus_we && in_ch) begin
            unique case (ofs)
                OFS_CFG:  reg_sel = SEL_CFG;
                OFS_DUTY: reg_sel = SEL_DUTY;
                OFS_PER:  reg_sel = SEL_PER;
                OFS_STG:  reg_sel = SEL_STG;
                default:  reg_sel = SEL_NONE;
            endcase
        end
        wr_cfg.psc = bus_wdata[3:0];
        wr_cfg.pol = bus_wdata[CFG_POL_BIT];
        wr_cfg.tgt = bus_wdata[CFG_TGT_BIT];
    end

    assign unused_wdata_hi = ^bus_wdata[31:CNT_W];

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        ch_reg_e sel_i;
        assign sel_i = (ch_idx == CH_IDX_W'(gi)) ? reg_sel : SEL_NONE;

        pwm_quad_chan #(
            .CNT_W   (CNT_W),
            .DIV_W   (DIV_W),
            .PSC_MAX (PSC_MAX)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_cnt (div_cnt),
            .set_run (start_hit && bus_wdata[gi]),
            .clr_run (stop_hit && bus_wdata[gi]),
            .wr_sel  (sel_i),
            .wr_val  (bus_wdata[CNT_W-1:0]),
            .wr_cfg  (wr_cfg),
            .pwm_o   (pwm_out[gi]),
            .run_o   (run_vec[gi]),
            .cfg_o   (cfg_arr[gi]),
            .duty_o  (duty_arr[gi]),
            .per_o   (per_arr[gi]),
            .pend_o  (pend_arr[gi]),
            .cnt_o   (cnt_arr[gi])
        );

        assign pol_vec[gi] = cfg_arr[gi].pol;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        rd_cfg    = cfg_arr[ch_idx];
        if (bus_addr == ADDR_W'(GLB_STATUS)) begin
            bus_rdata[NUM_CH-1:0] = run_vec;
        end else if (in_ch) begin
            unique case (ofs)
                OFS_CFG:  bus_rdata = {21'b0, rd_cfg.tgt, rd_cfg.pol, 5'b0, rd_cfg.psc};
                OFS_DUTY: bus_rdata = {{(32-CNT_W){1'b0}}, duty_arr[ch_idx]};
                OFS_PER:  bus_rdata = {{(32-CNT_W){1'b0}}, per_arr[ch_idx]};
                OFS_STG:  bus_rdata = {{(32-CNT_W){1'b0}}, pend_arr[ch_idx]};
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NUM_CH-1:0] ctl_bits,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] pol_vec,
    input logic [CNT_W-1:0]  cnt_arr [NUM_CH],
    input logic [CNT_W-1:0]  per_arr [NUM_CH]
);

    logic start_wr, stop_wr;
    assign start_wr = bus_we && (bus_addr == ADDR_W'(GLB_START));
    assign stop_wr  = bus_we && (bus_addr == ADDR_W'(GLB_STOP));

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
        a_r1_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
            (start_wr && ctl_bits[gi]) |=> run_vec[gi])
            else $error("R1 start write did not set run bit");

        a_r1_zero_bit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            ((start_wr || stop_wr) && !ctl_bits[gi]) |=> $stable(run_vec[gi]))
            else $error("R1 zero bit changed run state");

        a_r2_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_wr && ctl_bits[gi]) |=> !run_vec[gi])
            else $error("R2 stop write did not clear run bit");

        a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[gi] |-> (pwm_out[gi] == pol_vec[gi]) && (cnt_arr[gi] == '0))
            else $error("R2 stopped channel not idle at polarity");

        a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[gi] && per_arr[gi] != '0) |-> (cnt_arr[gi] < per_arr[gi]))
            else $error("R6 count reached period");

        a_r6_zero_period_level: assert property (@(posedge clk) disable iff (!rst_n)
            (per_arr[gi] == '0) |-> (pwm_out[gi] == pol_vec[gi]))
            else $error("R6 zero period not at polarity");

        a_r9_period_held_midway: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[gi] && $past(run_vec[gi]) && cnt_arr[gi] != '0) |-> $stable(per_arr[gi]))
            else $error("R9 period changed inside a period");
    end

endmodule

bind pwm_quad pwm_quad_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ctl_bits (bus_wdata[NUM_CH-1:0]),
    .pwm_out  (pwm_out),
    .run_vec  (run_vec),
    .pol_vec  (pol_vec),
    .cnt_arr  (cnt_arr),
    .per_arr  (per_arr)
);

// File: tb/test_pwm_quad.sv
module test_pwm_quad;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_START  = 12'h004;
    localparam logic [11:0] A_STOP   = 12'h008;
    localparam logic [11:0] A_STATUS = 12'h00C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    ch;
        logic  lvl;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_quad i_pwm_quad (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [11:0] ch_addr(int ch, int ofs);
        return 12'(32'h200 + ch * 32'h20 + ofs);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver side: both tasks start and end at a falling edge
    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_check(logic [11:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    // expected levels, one per cycle, starting with the state after the last write
    task automatic push_wave(int ch, logic pol, int per_a, int duty_a,
                             int per_b, int duty_b, int sw, int n, string tag);
        for (int k = 0; k < n; k++) begin
            exp_t it;
            int   p, d, ph;
            p  = (k < sw) ? per_a  : per_b;
            d  = (k < sw) ? duty_a : duty_b;
            it.ch  = ch;
            it.tag = tag;
            if (p == 0) begin
                it.lvl = pol;
            end else begin
                ph     = (k < sw) ? (k % p) : ((k - sw) % p);
                it.lvl = (ph < d) ? pol : ~pol;
            end
            sb_q.push_back(it);
        end
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic measure_run(int ch, int exp_len, string tag);
        logic lvl;
        int   len;
        int   guard;
        @(negedge clk); #2;
        lvl   = pwm_out[ch];
        guard = 0;
        while (pwm_out[ch] == lvl && guard < 5000) begin
            @(negedge clk); #2; guard++;
        end
        lvl = pwm_out[ch];
        len = 0;
        while (pwm_out[ch] == lvl && guard < 5000) begin
            @(negedge clk); #2; len++; guard++;
        end
        check(tag, 32'(len), 32'(exp_len));
        @(negedge clk);
    endtask

    // monitor: pops one expected level per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, 32'(pwm_out[it.ch]), 32'(it.lvl));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 outputs low", 32'(pwm_out), 32'h0);
        rd_check(A_STATUS, 32'h0, "R11 status clear");
        rd_check(ch_addr(1, 8), 32'h0, "R11 period zero");
        rd_check(ch_addr(2, 0), 32'h0, "R11 config zero");

        // R7 masking, R3 channel isolation
        bus_wr(ch_addr(0, 4), 32'hABCD_0003);
        rd_check(ch_addr(0, 4), 32'h3, "R7 duty upper bits dropped");
        bus_wr(ch_addr(0, 8), 32'h0001_0005);
        rd_check(ch_addr(0, 8), 32'h5, "R7 period upper bits dropped");
        rd_check(ch_addr(3, 8), 32'h0, "R3 other channel untouched");

        // R4 config fields
        bus_wr(ch_addr(2, 0), 32'h0000_0603);
        rd_check(ch_addr(2, 0), 32'h603, "R4 config readback");
        bus_wr(ch_addr(2, 0), 32'hFFFF_FFFF);
        rd_check(ch_addr(2, 0), 32'h60F, "R4 unused config bits read 0");
        bus_wr(ch_addr(2, 0), 32'h0);

        // R6 basic waveform, duty 2 of 5
        bus_wr(ch_addr(0, 4), 32'h2);
        bus_wr(A_START, 32'h1);
        push_wave(0, 1'b0, 5, 2, 5, 2, 1000, 15, "R6 duty 2 of period 5");
        rd_check(A_STATUS, 32'h1, "R1 status shows ch0");
        drain();

        // R8 direct writes ignored while running
        bus_wr(ch_addr(0, 4), 32'h4);
        rd_check(ch_addr(0, 4), 32'h2, "R8 duty write ignored while running");
        bus_wr(ch_addr(0, 8), 32'h9);
        rd_check(ch_addr(0, 8), 32'h5, "R8 period write ignored while running");

        // R2 stop, R9 staged duty lands at boundary
        bus_wr(A_STOP, 32'h1);
        check("R2 stopped at polarity", 32'(pwm_out[0]), 32'h0);
        rd_check(A_STATUS, 32'h0, "R2 status cleared");
        bus_wr(A_START, 32'h1);
        push_wave(0, 1'b0, 5, 2, 5, 4, 5, 20, "R9 staged duty after restart at count 0");
        bus_wr(ch_addr(0, 16), 32'h4);
        drain();
        rd_check(ch_addr(0, 4), 32'h4, "R9 duty loaded from staging");

        // R9 staged period
        bus_wr(A_STOP, 32'h1);
        bus_wr(ch_addr(0, 4), 32'h2);
        rd_check(ch_addr(0, 4), 32'h2, "R8 duty write while stopped");
        bus_wr(ch_addr(0, 0), 32'h400);
        bus_wr(A_START, 32'h1);
        push_wave(0, 1'b0, 5, 2, 3, 2, 5, 20, "R9 staged period");
        bus_wr(ch_addr(0, 16), 32'h3);
        drain();
        rd_check(ch_addr(0, 8), 32'h3, "R9 period loaded from staging");

        // R10 staging while stopped
        bus_wr(A_STOP, 32'h1);
        bus_wr(ch_addr(0, 0), 32'h0);
        bus_wr(ch_addr(0, 16), 32'h1);
        rd_check(ch_addr(0, 4), 32'h1, "R10 staged duty immediate when stopped");
        rd_check(ch_addr(0, 8), 32'h3, "R10 period untouched");

        // R4 polarity, R6 corner cases on ch1
        bus_wr(ch_addr(1, 0), 32'h200);
        check("R2 stopped ch1 at high polarity", 32'(pwm_out[1]), 32'h1);
        bus_wr(ch_addr(1, 8), 32'h4);
        bus_wr(ch_addr(1, 4), 32'h1);
        bus_wr(A_START, 32'h2);
        push_wave(1, 1'b1, 4, 1, 4, 1, 1000, 12, "R4 inverted polarity waveform");
        drain();
        bus_wr(A_STOP, 32'h2);
        bus_wr(ch_addr(1, 4), 32'h0);
        bus_wr(A_START, 32'h2);
        push_wave(1, 1'b1, 4, 0, 4, 0, 1000, 12, "R6 zero duty");
        drain();
        bus_wr(A_STOP, 32'h2);
        bus_wr(ch_addr(1, 4), 32'h4);
        bus_wr(A_START, 32'h2);
        push_wave(1, 1'b1, 4, 4, 4, 4, 1000, 12, "R6 duty equals period");
        drain();
        bus_wr(A_STOP, 32'h2);
        bus_wr(ch_addr(1, 8), 32'h0);
        bus_wr(ch_addr(1, 4), 32'h2);
        bus_wr(A_START, 32'h2);
        push_wave(1, 1'b1, 0, 2, 0, 2, 1000, 12, "R6 zero period");
        drain();

        // R1 per-bit start and stop
        bus_wr(A_START, 32'h1);
        rd_check(A_STATUS, 32'h3, "R1 start ch0 keeps ch1");
        bus_wr(A_STOP, 32'h1);
        rd_check(A_STATUS, 32'h2, "R1 stop ch0 keeps ch1");
        bus_wr(A_START, 32'h0);
        rd_check(A_STATUS, 32'h2, "R1 zero start write");
        bus_wr(A_STOP, 32'h0);
        rd_check(A_STATUS, 32'h2, "R1 zero stop write");
        bus_wr(A_START, 32'hF);
        rd_check(A_STATUS, 32'hF, "R1 start all");
        bus_wr(A_STOP, 32'hF);
        rd_check(A_STATUS, 32'h0, "R1 stop all");

        // R5 prescaler
        bus_wr(ch_addr(3, 8), 32'h2);
        bus_wr(ch_addr(3, 4), 32'h1);
        bus_wr(ch_addr(3, 0), 32'h2);
        bus_wr(A_START, 32'h8);
        measure_run(3, 4, "R5 exponent 2 run length");
        bus_wr(A_STOP, 32'h8);
        bus_wr(ch_addr(3, 0), 32'hA);
        bus_wr(A_START, 32'h8);
        measure_run(3, 1024, "R5 exponent 10 run length");
        bus_wr(A_STOP, 32'h8);
        bus_wr(ch_addr(3, 0), 32'hB);
        bus_wr(A_START, 32'h8);
        push_wave(3, 1'b0, 0, 0, 0, 0, 1000, 40, "R5 reserved exponent freezes count");
        drain();
        bus_wr(A_STOP, 32'h8);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule